// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block holds the programmer-visible data registers of a small CPU: two 8-bit accumulators (called A and B here), a 16-bit double accumulator formed from them with A as the upper byte, two 16-bit index registers X and Y, and a 16-bit stack pointer. It also holds the negative, zero and overflow condition bits. It carries out, in one clock each, the operations that move data between those registers: a plain copy, a full swap, a sign extension, and the two dedicated accumulator copies that also set the condition bits.

A decoder upstream presents an operation code together with a source select and a destination select. The unit applies the width rules of that operation, commits every write on the following rising edge, and shows the new register contents and condition bits at its outputs. A load operation writes an external value into any register so that the surrounding datapath can fill the file. Memory access and arithmetic are handled elsewhere.

Operation codes on `op`: 0 idle, 1 load, 2 transfer, 3 exchange, 4 sign extend, 5 copy A into B, 6 copy B into A, 7 reserved (no effect). Register selects on `src_sel`/`dst_sel`: 0 A, 1 B, 2 double accumulator, 3 X, 4 Y, 5 stack pointer; 6 and 7 are invalid.

Top module: `xfer_unit`

## Requirements
- R1: While `rst_n` is low, every register and all three condition bits are cleared on the rising edge.
- R2: `acc_d` always equals A as the high byte followed by B as the low byte; a write to the double accumulator changes both halves, and a write to A alone leaves B unchanged.
- R3: Load (op 1) writes `ld_data` into the destination; an 8-bit destination takes the low byte of `ld_data`.
- R4: Transfer (op 2) copies source to destination; an 8-bit source into a 16-bit destination is sign-extended from bit 7, a 16-bit source into an 8-bit destination gives its low byte, and the source register is not altered.
- R5: Exchange (op 3) between two registers of the same width swaps them completely, both writes taking effect on the same edge.
- R6: Exchange between an 8-bit and a 16-bit register gives the 16-bit one 0x00 followed by the byte and gives the 8-bit one the low byte of the 16-bit value; where the 16-bit register is the double accumulator, the 8-bit write takes precedence over the half it overlaps (exchange of A with the double accumulator therefore swaps A and B).
- R7: Sign extend (op 4) with an 8-bit source and a 16-bit destination writes the byte to the low half and copies of its bit 7 to the high half; any other pairing of widths has no effect.
- R8: Op 5 copies A into B and op 6 copies B into A; both set the negative bit to bit 7 of the copied byte, set the zero bit when the byte is 0x00 and clear the overflow bit.
- R9: Every operation other than op 5 and op 6 leaves the three condition bits unchanged.
- R10: A transfer or exchange whose source and destination are the same register leaves that register unchanged.
- R11: The idle code, the reserved code 7, and any transfer, exchange, load or sign extend that names an invalid select change no register and no condition bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Operation code |
| src_sel | input | 3 | Source register select |
| dst_sel | input | 3 | Destination register select |
| ld_data | input | 16 | Value written by the load operation |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| acc_d | output | 16 | Double accumulator, A high and B low |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| stk_p | output | 16 | Stack pointer |
| flag_n | output | 1 | Negative condition bit |
| flag_z | output | 1 | Zero condition bit |
| flag_v | output | 1 | Overflow condition bit |

## Verification
The hardest situation to reach is an exchange or transfer where the double accumulator meets one of its own halves, because two writes land on the same byte in one cycle and the result is only visible if A and B hold distinct, recognisable values beforehand. The stimulus first loads A and B with different bytes of opposite sign, then issues exchanges of A and of B with the double accumulator and transfers between them, followed by a long stream of pseudo-random operations and selects (invalid ones included) that keep revisiting these overlaps while a behavioural model predicts every register after each edge.

// File: rtl/xfer_unit.sv
module xfer_unit #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [2:0]    src_sel,
  input  logic [2:0]    dst_sel,
  input  logic [WW-1:0] ld_data,
  output logic [BW-1:0] acc_a,
  output logic [BW-1:0] acc_b,
  output logic [WW-1:0] acc_d,
  output logic [WW-1:0] idx_x,
  output logic [WW-1:0] idx_y,
  output logic [WW-1:0] stk_p,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v
);
  localparam logic [2:0] OP_LOAD = 3'd1;
  localparam logic [2:0] OP_TFR  = 3'd2;
  localparam logic [2:0] OP_EXG  = 3'd3;
  localparam logic [2:0] OP_SEX  = 3'd4;
  localparam logic [2:0] OP_TAB  = 3'd5;
  localparam logic [2:0] OP_TBA  = 3'd6;

  localparam logic [2:0] R_A  = 3'd0;
  localparam logic [2:0] R_B  = 3'd1;
  localparam logic [2:0] R_D  = 3'd2;
  localparam logic [2:0] R_X  = 3'd3;
  localparam logic [2:0] R_Y  = 3'd4;
  localparam logic [2:0] R_SP = 3'd5;

  logic [BW-1:0] ra, rb, na, nb;
  logic [WW-1:0] rx, ry, rs, nx, ny, ns;
  logic          fn, fz, fv, nfn, nfz, nfv;

  logic          wen [2];
  logic [2:0]    wsel [2];
  logic [WW-1:0] wval [2];
  logic [WW-1:0] src_raw, dst_raw;

  function automatic logic narrow(input logic [2:0] s);
    return (s == R_A) || (s == R_B);
  endfunction

  function automatic logic valid(input logic [2:0] s);
    return s <= R_SP;
  endfunction

  function automatic logic [WW-1:0] widen_signed(input logic [BW-1:0] v);
    return {{BW{v[BW-1]}}, v};
  endfunction

  always_comb begin
    case (src_sel)
      R_A:     src_raw = {{BW{1'b0}}, ra};
      R_B:     src_raw = {{BW{1'b0}}, rb};
      R_D:     src_raw = {ra, rb};
      R_X:     src_raw = rx;
      R_Y:     src_raw = ry;
      R_SP:    src_raw = rs;
      default: src_raw = '0;
    endcase
    case (dst_sel)
      R_A:     dst_raw = {{BW{1'b0}}, ra};
      R_B:     dst_raw = {{BW{1'b0}}, rb};
      R_D:     dst_raw = {ra, rb};
      R_X:     dst_raw = rx;
      R_Y:     dst_raw = ry;
      R_SP:    dst_raw = rs;
      default: dst_raw = '0;
    endcase
  end

  wire pair_ok  = valid(src_sel) && valid(dst_sel);
  wire up_width = narrow(src_sel) && !narrow(dst_sel);

  always_comb begin
    wen[0] = 1'b0; wsel[0] = dst_sel; wval[0] = '0;
    wen[1] = 1'b0; wsel[1] = src_sel; wval[1] = '0;
    case (op)
      OP_LOAD: begin
        wen[0]  = valid(dst_sel);
        wval[0] = ld_data;
      end
      OP_TFR: begin
        wen[0]  = pair_ok;
        wval[0] = up_width ? widen_signed(src_raw[BW-1:0]) : src_raw;
      end
      OP_EXG: begin
        wen[0]  = pair_ok;
        wval[0] = src_raw;
        wen[1]  = pair_ok;
        wval[1] = dst_raw;
      end
      OP_SEX: begin
        wen[0]  = pair_ok && up_width;
        wval[0] = widen_signed(src_raw[BW-1:0]);
      end
      OP_TAB: begin
        wen[0]  = 1'b1;
        wsel[0] = R_B;
        wval[0] = {{BW{1'b0}}, ra};
      end
      OP_TBA: begin
        wen[0]  = 1'b1;
        wsel[0] = R_A;
        wval[0] = {{BW{1'b0}}, rb};
      end
      default: ;
    endcase
  end

  always_comb begin
    na = ra; nb = rb; nx = rx; ny = ry; ns = rs;
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < 2; p++) begin
        if (wen[p] && (narrow(wsel[p]) == (pass == 1))) begin
          case (wsel[p])
            R_A:     na = wval[p][BW-1:0];
            R_B:     nb = wval[p][BW-1:0];
            R_D:     {na, nb} = wval[p];
            R_X:     nx = wval[p];
            R_Y:     ny = wval[p];
            R_SP:    ns = wval[p];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    nfn = fn; nfz = fz; nfv = fv;
    if (op == OP_TAB) begin
      nfn = ra[BW-1]; nfz = (ra == '0); nfv = 1'b0;
    end else if (op == OP_TBA) begin
      nfn = rb[BW-1]; nfz = (rb == '0); nfv = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra <= '0; rb <= '0; rx <= '0; ry <= '0; rs <= '0;
      fn <= 1'b0; fz <= 1'b0; fv <= 1'b0;
    end else begin
      ra <= na; rb <= nb; rx <= nx; ry <= ny; rs <= ns;
      fn <= nfn; fz <= nfz; fv <= nfv;
    end
  end

  assign acc_a  = ra;
  assign acc_b  = rb;
  assign acc_d  = {ra, rb};
  assign idx_x  = rx;
  assign idx_y  = ry;
  assign stk_p  = rs;
  assign flag_n = fn;
  assign flag_z = fz;
  assign flag_v = fv;
endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic [2:0]    src_sel,
  input logic [2:0]    dst_sel,
  input logic [BW-1:0] acc_a,
  input logic [BW-1:0] acc_b,
  input logic [WW-1:0] idx_x,
  input logic [WW-1:0] idx_y,
  input logic [WW-1:0] stk_p,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_v
);
  p_load_a_keeps_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && dst_sel == 3'd0) |=> acc_b == $past(acc_b));

  p_tfr_src_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && src_sel == 3'd3 && dst_sel != 3'd3 && dst_sel < 3'd6)
    |=> idx_x == $past(idx_x));

  p_tfr_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && src_sel == 3'd0 && dst_sel == 3'd4)
    |=> idx_y == {{BW{$past(acc_a[BW-1])}}, $past(acc_a)});

  p_exg_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && src_sel == 3'd3 && dst_sel == 3'd5)
    |=> (idx_x == $past(stk_p)) && (stk_p == $past(idx_x)));

  p_exg_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && src_sel == 3'd1 && dst_sel == 3'd4)
    |=> (idx_y == {{BW{1'b0}}, $past(acc_b)}) && (acc_b == $past(idx_y[BW-1:0])));

  p_sex_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && src_sel == 3'd1 && dst_sel == 3'd3)
    |=> idx_x == {{BW{$past(acc_b[BW-1])}}, $past(acc_b)});

  p_tab_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5) |=> (acc_b == $past(acc_a)) && (flag_n == $past(acc_a[BW-1]))
                     && (flag_z == ($past(acc_a) == '0)) && !flag_v);

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'd5 && op != 3'd6) |=> $stable(flag_n) && $stable(flag_z) && $stable(flag_v));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op == 3'd7)
    |=> $stable(acc_a) && $stable(acc_b) && $stable(idx_x) && $stable(idx_y) && $stable(stk_p));
endmodule

bind xfer_unit xfer_unit_chk #(.BW(BW)) chk (
  .clk(clk), .rst_n(rst_n), .op(op), .src_sel(src_sel), .dst_sel(dst_sel),
  .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y), .stk_p(stk_p),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
);

// File: tb/xfer_unit_test.sv
module xfer_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0, src_sel = '0, dst_sel = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  acc_a, acc_b;
  logic [15:0] acc_d, idx_x, idx_y, stk_p;
  logic        flag_n, flag_z, flag_v;

  int checks = 0, fails = 0;
  bit done = 0;
  int ma, mb, mx, my, ms;
  bit mn, mz, mv;

  always #4 clk = ~clk;

  xfer_unit uut (.clk(clk), .rst_n(rst_n), .op(op), .src_sel(src_sel), .dst_sel(dst_sel),
    .ld_data(ld_data), .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d), .idx_x(idx_x),
    .idx_y(idx_y), .stk_p(stk_p), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v));

  function automatic bit is8(int s); return s < 2; endfunction

  function automatic int rget(int s);
    case (s)
      0: return ma;
      1: return mb;
      2: return ma * 256 + mb;
      3: return mx;
      4: return my;
      5: return ms;
      default: return 0;
    endcase
  endfunction

  task automatic put(int s, int v);
    v = v & 16'hFFFF;
    case (s)
      0: ma = v & 255;
      1: mb = v & 255;
      2: begin ma = v >> 8; mb = v & 255; end
      3: mx = v;
      4: my = v;
      5: ms = v;
      default: ;
    endcase
  endtask

  task automatic model(int o, int s, int d, int data);
    int vs, vd;
    vs = rget(s);
    vd = rget(d);
    case (o)
      1: if (d < 6) put(d, data);
      2: if (s < 6 && d < 6) begin
           if (is8(s) && !is8(d) && vs >= 128) vs = vs | 16'hFF00;
           put(d, vs);
         end
      3: if (s < 6 && d < 6) begin
           if (is8(d) && !is8(s)) begin put(s, vd); put(d, vs); end
           else begin put(d, vs); put(s, vd); end
         end
      4: if (is8(s) && d < 6 && !is8(d)) begin
           if (vs >= 128) vs = vs | 16'hFF00;
           put(d, vs);
         end
      5: begin mb = ma; mn = ma >= 128; mz = ma == 0; mv = 0; end
      6: begin ma = mb; mn = mb >= 128; mz = mb == 0; mv = 0; end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "acc_a", acc_a, ma);
    chk(tag, "acc_b", acc_b, mb);
    chk(tag, "acc_d", acc_d, ma * 256 + mb);
    chk(tag, "idx_x", idx_x, mx);
    chk(tag, "idx_y", idx_y, my);
    chk(tag, "stk_p", stk_p, ms);
    chk(tag, "flag_n", flag_n, mn);
    chk(tag, "flag_z", flag_z, mz);
    chk(tag, "flag_v", flag_v, mv);
  endtask

  task automatic do_op(int o, int s, int d, int data, string tag);
    op = 3'(o); src_sel = 3'(s); dst_sel = 3'(d); ld_data = 16'(data);
    @(posedge clk);
    model(o, s, d, data);
    @(negedge clk);
    compare_all(tag);
    op = '0;
  endtask

  function automatic string tag_of(int o);
    case (o)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5, 6: return "R8";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    ma = 0; mb = 0; mx = 0; my = 0; ms = 0; mn = 0; mz = 0; mv = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;

    do_op(1, 0, 0, 16'h1285, "R3");
    do_op(1, 0, 1, 16'h003C, "R3");
    do_op(1, 0, 0, 16'h0090, "R2");
    do_op(1, 0, 3, 16'h1234, "R3");
    do_op(1, 0, 4, 16'hFEDC, "R3");
    do_op(1, 0, 5, 16'h8000, "R3");
    do_op(2, 0, 3, 0, "R4");
    do_op(2, 1, 4, 0, "R4");
    do_op(2, 5, 0, 0, "R4");
    do_op(1, 0, 2, 16'hA55A, "R2");
    do_op(2, 2, 5, 0, "R4");
    do_op(2, 4, 1, 0, "R4");
    do_op(2, 3, 3, 0, "R10");
    do_op(3, 1, 1, 0, "R10");
    do_op(3, 3, 4, 0, "R5");
    do_op(3, 0, 1, 0, "R5");
    do_op(3, 2, 5, 0, "R5");
    do_op(3, 0, 4, 0, "R6");
    do_op(3, 0, 2, 0, "R6");
    do_op(3, 2, 1, 0, "R6");
    do_op(1, 0, 2, 16'h7F81, "R2");
    do_op(2, 0, 2, 0, "R2");
    do_op(4, 1, 3, 0, "R7");
    do_op(4, 0, 2, 0, "R7");
    do_op(4, 3, 4, 0, "R7");
    do_op(4, 0, 1, 0, "R7");
    do_op(1, 0, 0, 16'h0000, "R3");
    do_op(5, 0, 0, 0, "R8");
    do_op(1, 0, 1, 16'h00C3, "R3");
    do_op(6, 0, 0, 0, "R8");
    do_op(2, 3, 4, 0, "R9");
    do_op(3, 4, 0, 0, "R9");
    do_op(1, 0, 5, 16'h0001, "R9");
    do_op(2, 6, 3, 0, "R11");
    do_op(3, 1, 7, 0, "R11");
    do_op(1, 0, 6, 16'hFFFF, "R11");
    do_op(7, 0, 3, 0, "R11");
    do_op(0, 2, 3, 0, "R11");

    seed = 7;
    for (int i = 0; i < 400; i++) begin
      int o, s, d, v;
      seed = seed * 1103515245 + 12345;
      o = (seed >>> 16) & 7;
      s = (seed >>> 8) & 7;
      seed = seed * 1103515245 + 12345;
      d = (seed >>> 16) & 7;
      v = (seed >>> 3) & 16'hFFFF;
      if (s > 5 && (i % 3) != 0) s = s - 6;
      if (d > 5 && (i % 3) != 1) d = d - 6;
      do_op(o, s, d, v, tag_of(o));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule